// File: doc/BRIEF.md
# Type-C Lane Assignment Crossbar

This block decides how the four pads of a combined DisplayPort / SuperSpeed USB transceiver are used. For each pad it chooses USB receive, USB transmit, a DisplayPort lane, or idle. For each DisplayPort logical lane it names the pad that carries it. It also drives the operating mode and the AUX channel polarity. Pads 0 and 2 can both transmit and receive. Pads 1 and 3 can only transmit.

Software or a connector manager presents a configuration and pulses `load_i`. There are three kinds of configuration:
- the built-in table for the sensed plug orientation;
- no lane list at all, which gives USB only;
- an explicit list of two or four pad numbers, where entry i names the pad for DisplayPort lane i.

The block validates an explicit list before using it. A bad list leaves the current routing in place and raises a one-cycle error pulse. All outputs are registered.

Top module: `typec_lane_xbar`

## Requirements
- R1: After reset the outputs are `pad_fn_o`=8'hF4, `lane_pad_o`=8'hE4, `mode_o`=1, both AUX inversion bits 0, `err_o`=0. Pad p's 2-bit code sits at bits [2p+1:2p] of `pad_fn_o`. The codes are 0 = USB receive, 1 = USB transmit, 2 = DP, 3 = idle. Lane l's pad number sits at bits [2l+1:2l] of `lane_pad_o`.
- R2: Outputs change only at the first rising edge with `load_i` high, and they show the new routing from that edge on. Without `load_i`, changes on every other input have no effect.
- R3: With `use_default_i`=0 and `list_count_i`=0, the mode is USB only (`mode_o`=1, where bit0 = USB and bit1 = DP). USB receive/transmit go to pads 0/1 when `flip_i`=0 and to pads 2/3 when `flip_i`=1. Unused pads are idle, lanes are identity (8'hE4), and AUX is normal.
- R4: With `use_default_i`=1 and `flip_i`=0, pads 0/1 carry USB receive/transmit and pads 2/3 carry DP. Lanes 0..3 map to pads 2,3,1,0, the mode is 3, and AUX is normal.
- R5: With `use_default_i`=1 and `flip_i`=1, pads 0/1 carry DP and pads 2/3 carry USB receive/transmit. Lanes 0..3 map to pads 0,1,3,2, the mode is 3, and both AUX inversion bits are 1.
- R6: A valid four-entry list gives `mode_o`=2, all pads DP, lane i on pad entry i, and AUX normal. Entry i of `list_i` sits at bits [3i+2:3i].
- R7: A valid two-entry list gives `mode_o`=3. The pads it names carry DP lanes 0 and 1. On the other pad pair, USB receive sits on the even pad and USB transmit on the odd pad. Lanes 2 and 3 take that pair's even and odd pad.
- R8: When `use_default_i`=0, a `list_count_i` other than 0, 2 or 4 is an error.
- R9: An entry above 3, or two equal entries among the first `list_count_i` entries, is an error. Entries beyond the count are ignored.
- R10: A two-entry list whose pads are not both in {0,1} or both in {2,3} is an error, because the USB receive pad would otherwise not be next to its transmit pad.
- R11: On an error, all routing outputs keep their previous values, and `err_o` is high for exactly the one cycle after the load.
- R12: `flip_i` has no effect on an explicit list, and the list fields have no effect when `use_default_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Apply the presented configuration |
| use_default_i | input | 1 | Use the orientation table and ignore the list |
| flip_i | input | 1 | Plug is inserted flipped |
| list_count_i | input | 3 | Number of list entries (0 = no list) |
| list_i | input | 12 | Four 3-bit pad numbers, entry i at [3i+2:3i] |
| pad_fn_o | output | 8 | Per-pad function code |
| lane_pad_o | output | 8 | Per-DP-lane pad number |
| mode_o | output | 2 | bit0 USB active, bit1 DP active |
| aux_tx_inv_o | output | 1 | Invert AUX output data |
| aux_rx_inv_o | output | 1 | Invert AUX input data |
| err_o | output | 1 | One-cycle pulse for a rejected list |

## Verification
If the validator holds a wrong verdict, it shows one cycle after the load: either `err_o` pulses while the routing changes, or a bad list alters `pad_fn_o`. If the map builder is wrong, the pad codes and lane numbers on the ports are off at that same edge. The mode is checked against the number of DP pads on every cycle, so a mode register that disagrees with the pad map is caught in the cycle it appears. A held register that leaks is seen when inputs move with `load_i` low.

// File: rtl/typec_lane_xbar_pkg.sv
package typec_lane_xbar_pkg;
  localparam int NUM_PADS = 4;
  localparam int SEL_W    = 2;

  typedef enum logic [1:0] {
    PAD_USB_RX = 2'd0,
    PAD_USB_TX = 2'd1,
    PAD_DP     = 2'd2,
    PAD_IDLE   = 2'd3
  } pad_fn_e;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_USB    = 2'd1,
    MODE_DP     = 2'd2,
    MODE_DP_USB = 2'd3
  } xbar_mode_e;

  typedef struct packed {
    logic [NUM_PADS-1:0][SEL_W-1:0] pad_fn;
    logic [NUM_PADS-1:0][SEL_W-1:0] lane_pad;
    logic [1:0]                     mode;
    logic                           aux_inv;
  } route_t;

  // USB pair base pad: the even pad of the pair not used by DP
  function automatic logic [SEL_W-1:0] other_pair_base(input logic [SEL_W-1:0] dp_pad);
    return {~dp_pad[1], 1'b0};
  endfunction

  function automatic logic [SEL_W-1:0] other_pair_odd(input logic [SEL_W-1:0] dp_pad);
    return {~dp_pad[1], 1'b1};
  endfunction
endpackage

// File: rtl/lane_list_check.sv
module lane_list_check #(
  parameter int ENT_W = 3,
  parameter int CNT_W = 3,
  localparam int NP   = typec_lane_xbar_pkg::NUM_PADS
) (
  input  logic                  use_default_i,
  input  logic [CNT_W-1:0]      count_i,
  input  logic [NP-1:0][ENT_W-1:0] ent_i,
  output logic                  bad_o
);
  logic count_bad, range_bad, dup_bad, pair_bad;

  always_comb begin
    count_bad = !(count_i == CNT_W'(0) || count_i == CNT_W'(2) || count_i == CNT_W'(4));
    range_bad = 1'b0;
    dup_bad   = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (CNT_W'(i) < count_i) begin
        if (ent_i[i] > ENT_W'(NP-1)) range_bad = 1'b1;
        for (int j = i + 1; j < NP; j++) begin
          if (CNT_W'(j) < count_i && ent_i[i] == ent_i[j]) dup_bad = 1'b1;
        end
      end
    end
    // two-lane split must leave an aligned pad pair for USB
    pair_bad = (count_i == CNT_W'(2)) && (ent_i[0][1] != ent_i[1][1]);
    bad_o = !use_default_i && (count_bad || range_bad || dup_bad || pair_bad);
  end
endmodule

// File: rtl/lane_map_build.sv
module lane_map_build
  import typec_lane_xbar_pkg::*;
#(
  parameter int ENT_W = 3,
  parameter int CNT_W = 3,
  localparam int NP   = NUM_PADS
) (
  input  logic                     use_default_i,
  input  logic                     flip_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [NP-1:0][ENT_W-1:0] ent_i,
  output route_t                   route_o
);
  logic [SEL_W-1:0] e0, e1;
  assign e0 = ent_i[0][SEL_W-1:0];
  assign e1 = ent_i[1][SEL_W-1:0];

  always_comb begin
    route_o.aux_inv = 1'b0;
    route_o.mode    = MODE_USB;
    for (int p = 0; p < NP; p++) begin
      route_o.pad_fn[p]   = PAD_IDLE;
      route_o.lane_pad[p] = SEL_W'(p);
    end
    if (use_default_i) begin
      route_o.mode = MODE_DP_USB;
      if (flip_i) begin
        route_o.pad_fn  = {PAD_USB_TX, PAD_USB_RX, PAD_DP, PAD_DP};
        route_o.lane_pad = {2'd2, 2'd3, 2'd1, 2'd0};
        route_o.aux_inv = 1'b1;
      end else begin
        route_o.pad_fn  = {PAD_DP, PAD_DP, PAD_USB_TX, PAD_USB_RX};
        route_o.lane_pad = {2'd0, 2'd1, 2'd3, 2'd2};
      end
    end else if (count_i == CNT_W'(0)) begin
      route_o.mode = MODE_USB;
      route_o.pad_fn[{flip_i, 1'b0}] = PAD_USB_RX;
      route_o.pad_fn[{flip_i, 1'b1}] = PAD_USB_TX;
    end else if (count_i == CNT_W'(4)) begin
      route_o.mode = MODE_DP;
      for (int i = 0; i < NP; i++) begin
        route_o.pad_fn[ent_i[i][SEL_W-1:0]] = PAD_DP;
        route_o.lane_pad[i] = ent_i[i][SEL_W-1:0];
      end
    end else begin
      route_o.mode = MODE_DP_USB;
      route_o.pad_fn[e0] = PAD_DP;
      route_o.pad_fn[e1] = PAD_DP;
      route_o.pad_fn[other_pair_base(e0)] = PAD_USB_RX;
      route_o.pad_fn[other_pair_odd(e0)]  = PAD_USB_TX;
      route_o.lane_pad[0] = e0;
      route_o.lane_pad[1] = e1;
      route_o.lane_pad[2] = other_pair_base(e0);
      route_o.lane_pad[3] = other_pair_odd(e0);
    end
  end
endmodule

// File: rtl/typec_lane_xbar.sv
module typec_lane_xbar
  import typec_lane_xbar_pkg::*;
#(
  parameter int ENT_W = 3,
  parameter int CNT_W = 3,
  localparam int NP     = NUM_PADS,
  localparam int LIST_W = NP * ENT_W,
  localparam int MAP_W  = NP * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              use_default_i,
  input  logic              flip_i,
  input  logic [CNT_W-1:0]  list_count_i,
  input  logic [LIST_W-1:0] list_i,
  output logic [MAP_W-1:0]  pad_fn_o,
  output logic [MAP_W-1:0]  lane_pad_o,
  output logic [1:0]        mode_o,
  output logic              aux_tx_inv_o,
  output logic              aux_rx_inv_o,
  output logic              err_o
);
  logic [NP-1:0][ENT_W-1:0] ent;
  logic   list_bad;
  route_t next_route, route_q;
  logic   err_q;

  assign ent = list_i;

  lane_list_check #(.ENT_W(ENT_W), .CNT_W(CNT_W)) u_check (
    .use_default_i (use_default_i),
    .count_i       (list_count_i),
    .ent_i         (ent),
    .bad_o         (list_bad)
  );

  lane_map_build #(.ENT_W(ENT_W), .CNT_W(CNT_W)) u_build (
    .use_default_i (use_default_i),
    .flip_i        (flip_i),
    .count_i       (list_count_i),
    .ent_i         (ent),
    .route_o       (next_route)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q.mode    <= MODE_USB;
      route_q.aux_inv <= 1'b0;
      route_q.pad_fn  <= {PAD_IDLE, PAD_IDLE, PAD_USB_TX, PAD_USB_RX};
      route_q.lane_pad <= {2'd3, 2'd2, 2'd1, 2'd0};
      err_q           <= 1'b0;
    end else begin
      err_q <= load_i && list_bad;
      if (load_i && !list_bad) route_q <= next_route;
    end
  end

  assign pad_fn_o     = route_q.pad_fn;
  assign lane_pad_o   = route_q.lane_pad;
  assign mode_o       = route_q.mode;
  assign aux_tx_inv_o = route_q.aux_inv;
  assign aux_rx_inv_o = route_q.aux_inv;
  assign err_o        = err_q;
endmodule

// File: rtl/typec_lane_xbar_chk.sv
module typec_lane_xbar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_i,
  input logic [7:0] pad_fn_o,
  input logic [7:0] lane_pad_o,
  input logic [1:0] mode_o,
  input logic       aux_tx_inv_o,
  input logic       aux_rx_inv_o,
  input logic       err_o
);
  logic [3:0] dp_pads;
  for (genvar p = 0; p < 4; p++) begin : g_dp
    assign dp_pads[p] = (pad_fn_o[2*p+1:2*p] == 2'd2);
  end

  // R11: a rejected list leaves the routing untouched
  a_r11_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(pad_fn_o) && $stable(lane_pad_o) && $stable(mode_o)));

  // R2: an error pulse only follows a load
  a_r2_err_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> !err_o);

  // R2: no load, no change
  a_r2_hold_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(pad_fn_o) && $stable(lane_pad_o) && $stable(mode_o)
                 && $stable(aux_tx_inv_o)));

  // R6: DP-only mode puts every pad on DP
  a_r6_dp_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (dp_pads == 4'hF));

  // R7: split mode has exactly two DP pads
  a_r7_split_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |-> ($countones(dp_pads) == 2));

  // R3: USB-only mode has no DP pad
  a_r3_usb_no_dp: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (dp_pads == 4'h0));

  // R7: USB receive never sits on a transmit-only pad
  a_r7_rx_even_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_fn_o[3:2] != 2'd0) && (pad_fn_o[7:6] != 2'd0));

  // R5: both AUX directions invert together
  a_r5_aux_pair: assert property (@(posedge clk) disable iff (!rst_n)
    aux_tx_inv_o == aux_rx_inv_o);
endmodule

bind typec_lane_xbar typec_lane_xbar_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .pad_fn_o     (pad_fn_o),
  .lane_pad_o   (lane_pad_o),
  .mode_o       (mode_o),
  .aux_tx_inv_o (aux_tx_inv_o),
  .aux_rx_inv_o (aux_rx_inv_o),
  .err_o        (err_o)
);

// File: tb/test_typec_lane_xbar.sv
module test_typec_lane_xbar;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, load_i, use_default_i, flip_i;
  logic [2:0]  list_count_i;
  logic [11:0] list_i;
  logic [7:0]  pad_fn_o, lane_pad_o;
  logic [1:0]  mode_o;
  logic        aux_tx_inv_o, aux_rx_inv_o, err_o;

  typec_lane_xbar i_typec_lane_xbar (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct packed {
    logic       ud; logic fl; logic [2:0] cnt; logic [11:0] lst;
    logic [7:0] pf; logic [7:0] lp; logic [1:0] md; logic ai; logic er;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,3'd0,12'h000, 8'hF4,8'hE4,2'd1,1'b0,1'b0}, // R3 normal
    '{1'b0,1'b1,3'd0,12'h000, 8'h4F,8'hE4,2'd1,1'b0,1'b0}, // R3 flipped
    '{1'b1,1'b0,3'd0,12'h000, 8'hA4,8'h1E,2'd3,1'b0,1'b0}, // R4
    '{1'b1,1'b1,3'd0,12'h000, 8'h4A,8'hB4,2'd3,1'b1,1'b0}, // R5
    '{1'b0,1'b0,3'd4,{3'd3,3'd2,3'd1,3'd0}, 8'hAA,8'hE4,2'd2,1'b0,1'b0}, // R6
    '{1'b0,1'b0,3'd4,{3'd1,3'd0,3'd3,3'd2}, 8'hAA,8'h4E,2'd2,1'b0,1'b0}, // R6
    '{1'b0,1'b1,3'd4,{3'd1,3'd2,3'd0,3'd3}, 8'hAA,8'h63,2'd2,1'b0,1'b0}, // R6 R12
    '{1'b0,1'b0,3'd2,{3'd0,3'd0,3'd1,3'd0}, 8'h4A,8'hE4,2'd3,1'b0,1'b0}, // R7
    '{1'b0,1'b0,3'd2,{3'd0,3'd0,3'd2,3'd3}, 8'hA4,8'h4B,2'd3,1'b0,1'b0}, // R7
    '{1'b0,1'b1,3'd2,{3'd0,3'd0,3'd0,3'd1}, 8'h4A,8'hE1,2'd3,1'b0,1'b0}, // R7 R12
    '{1'b0,1'b0,3'd3,{3'd0,3'd2,3'd1,3'd0}, 8'h00,8'h00,2'd0,1'b0,1'b1}, // R8
    '{1'b0,1'b0,3'd1,{3'd0,3'd0,3'd0,3'd0}, 8'h00,8'h00,2'd0,1'b0,1'b1}, // R8
    '{1'b0,1'b0,3'd5,{3'd3,3'd2,3'd1,3'd0}, 8'h00,8'h00,2'd0,1'b0,1'b1}, // R8
    '{1'b0,1'b0,3'd4,{3'd4,3'd2,3'd1,3'd0}, 8'h00,8'h00,2'd0,1'b0,1'b1}, // R9
    '{1'b0,1'b0,3'd4,{3'd3,3'd2,3'd1,3'd1}, 8'h00,8'h00,2'd0,1'b0,1'b1}, // R9
    '{1'b0,1'b0,3'd2,{3'd0,3'd0,3'd2,3'd0}, 8'h00,8'h00,2'd0,1'b0,1'b1}, // R10
    '{1'b0,1'b0,3'd2,{3'd0,3'd0,3'd4,3'd1}, 8'h00,8'h00,2'd0,1'b0,1'b1}, // R9
    '{1'b0,1'b0,3'd2,{3'd7,3'd7,3'd3,3'd2}, 8'hA4,8'h4E,2'd3,1'b0,1'b0}, // R9 ignored tail
    '{1'b1,1'b0,3'd3,{3'd7,3'd7,3'd7,3'd7}, 8'hA4,8'h1E,2'd3,1'b0,1'b0}, // R12
    '{1'b0,1'b0,3'd2,{3'd0,3'd0,3'd2,3'd1}, 8'h00,8'h00,2'd0,1'b0,1'b1}  // R10
  };

  function automatic logic [20:0] outs();
    return {pad_fn_o, lane_pad_o, mode_o, aux_tx_inv_o, aux_rx_inv_o, err_o};
  endfunction

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    use_default_i = v.ud; flip_i = v.fl; list_count_i = v.cnt; list_i = v.lst;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [20:0] held;
    rst_n = 1'b0; load_i = 1'b0; use_default_i = 1'b0; flip_i = 1'b0;
    list_count_i = '0; list_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", outs(), {8'hF4, 8'hE4, 2'd1, 1'b0, 1'b0, 1'b0});

    held = {8'hF4, 8'hE4, 2'd1, 1'b0, 1'b0, 1'b0};
    for (int k = 0; k < NV; k++) begin
      apply(TBL[k]);
      if (TBL[k].er) begin
        check("R11 error hold (R8 R9 R10 vector)", outs(), {held[20:1], 1'b1});
      end else begin
        held = {TBL[k].pf, TBL[k].lp, TBL[k].md, TBL[k].ai, TBL[k].ai, 1'b0};
        check("R3-R7 R12 table vector", outs(), held);
      end
    end

    // R11: error pulse lasts one cycle
    apply(TBL[10]);
    @(negedge clk);
    check("R11 err drops", outs(), {held[20:1], 1'b0});

    // R2: inputs move without load, nothing changes
    use_default_i = 1'b1; flip_i = 1'b1; list_count_i = 3'd4; list_i = 12'hFFF;
    repeat (4) @(negedge clk);
    check("R2 hold without load", outs(), {held[20:1], 1'b0});

    // R2: output still old while load is presented, new after edge
    @(negedge clk);
    use_default_i = 1'b1; flip_i = 1'b1; load_i = 1'b1;
    #1;
    check("R2 before edge", outs(), {held[20:1], 1'b0});
    @(negedge clk);
    load_i = 1'b0;
    check("R2 after edge R5", outs(), {8'h4A, 8'hB4, 2'd3, 1'b1, 1'b1, 1'b0});

    // R1: reset mid-run restores the reset routing
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset again", outs(), {8'hF4, 8'hE4, 2'd1, 1'b0, 1'b0, 1'b0});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule